// File: doc/BRIEF.md
# Expanded Memory Page Mapper

This block maps CPU accesses that land in a 64 KB window of upper memory onto DRAM pages. The window is split into four 16 KB slots. Each slot has its own page register, holding an enable bit and a 7-bit page number. The window's base address, the I/O address of the page registers, a 2-bit extension per slot, the size of the paged pool and a global enable all come in as configuration inputs from the chipset's configuration logic.

Software programs a slot through an I/O write and can read it back through an I/O read. Each CPU access is offered with a strobe. The block answers one cycle later with a translated physical address and a hit flag. An access that misses comes back unchanged, with the hit flag low.

The result path is a two-state machine. ST_IDLE means no result is being presented; ST_DRIVE means the output registers hold the result of the previous cycle's access. The transitions are:
- T_ACCEPT: ST_IDLE to ST_DRIVE on a strobe.
- T_STREAM: ST_DRIVE to ST_DRIVE on a back-to-back strobe.
- T_RELEASE: ST_DRIVE to ST_IDLE when no strobe arrives.
- T_WAIT: ST_IDLE to ST_IDLE with no strobe.

Top module: `xmem_page_mapper`

## Requirements
- R1: After reset every page register reads back as 0x00, and `xl_valid`, `xl_hit` and `io_rvalid` are low.
- R2: The register of slot i answers at I/O addresses i×0x4000 + 0x208 + 0x10×`cfg_io_sel` and at that address + 1. Reads and writes at any other I/O address leave every page register unchanged.
- R3: An I/O write to a slot's register stores bit 7 as the slot enable and bits 6:0 as the page number. An I/O read returns the same byte, enable in bit 7, one cycle later with `io_rvalid` high. A read that matches no slot leaves `io_rvalid` low.
- R4: The window starts at 0xC0000 + 0x4000×`cfg_frame_sel` and spans 64 KB. The slot index is (address − window start) / 0x4000, so slot 0 is lowest.
- R5: An access hits only when all of the following hold: `cfg_ems_en` is high, the slot is enabled, the address is inside the window, and the physical page number p satisfies 0x40 ≤ p < 0x40 + page count.
- R6: The page count is 32 << `cfg_size_code`, giving 512 KB, 1 MB, 2 MB or 4 MB for codes 0 to 3.
- R7: The physical page number p is {ext, page number}, where the 2-bit ext of slot i is `cfg_ext`[7−2i:6−2i] (slot 0 in bits 7:6). On a hit, `xl_addr` = p×0x4000 + address[13:0].
- R8: On a miss, `xl_addr` equals the CPU address zero-extended to 23 bits, and `xl_hit` is low.
- R9: `xl_valid` is high in exactly the cycle after each strobe, following the FSM transitions T_ACCEPT, T_STREAM, T_RELEASE and T_WAIT. `xl_hit` is low whenever `xl_valid` is low.
- R10: A page-register write takes effect for a strobe in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ems_en | input | 1 | Global paging enable |
| cfg_frame_sel | input | 2 | Window base select |
| cfg_io_sel | input | 3 | Page-register I/O base select |
| cfg_ext | input | 8 | Per-slot 2-bit page extensions, slot 0 in bits 7:6 |
| cfg_size_code | input | 2 | Paged pool size code |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| io_rvalid | output | 1 | Read data valid, one cycle after a matching read |
| cpu_strobe | input | 1 | CPU access strobe |
| cpu_addr | input | 20 | CPU address |
| xl_valid | output | 1 | Translation result valid |
| xl_hit | output | 1 | Access was mapped |
| xl_addr | output | 23 | Translated or passed-through address |

## Verification
The bench uses the package defaults of four slots, a 2-bit window select, a 3-bit I/O select and a 2-bit size code. At these sizes every I/O base and window base combination can be swept in full: all 32 of them, with read-back and aliasing checks at each. At a fixed base, every 7-bit page number is swept through slot registers under all four size codes and five extension patterns. This puts both edges of the valid page range at every pool size within reach, along with the window edges and the disabled cases.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
    localparam int NUM_PAGES        = 4;
    localparam int PAGE_IDX_W       = $clog2(NUM_PAGES);
    localparam int PAGE_OFF_W       = 14;
    localparam int PAGE_LO_W        = 7;
    localparam int PAGE_EXT_W       = 2;
    localparam int PNUM_W           = PAGE_LO_W + PAGE_EXT_W;
    localparam int EXT_REG_W        = NUM_PAGES * PAGE_EXT_W;
    localparam int CPU_AW           = 20;
    localparam int PHYS_AW          = PNUM_W + PAGE_OFF_W;
    localparam int IO_AW            = 16;
    localparam int IO_DW            = 8;
    localparam int FRAME_SEL_W      = 2;
    localparam int IO_SEL_W         = 3;
    localparam int SIZE_W           = 2;
    localparam int COUNT_W          = PNUM_W + 1;
    localparam int WIN_OFF_W        = PAGE_OFF_W + PAGE_IDX_W;
    localparam logic [CPU_AW-1:0] FRAME_BASE = 20'hC0000;
    localparam logic [IO_AW-3:0]  IO_BASE    = 14'h208;
    localparam int IO_STEP_SH       = 4;
    localparam int FIRST_PAGE       = 'h40;
    localparam int BASE_PAGES       = 32;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRIVE = 1'b1
    } xl_state_e;

    typedef struct packed {
        logic                 en;
        logic [PAGE_LO_W-1:0] num;
    } page_reg_t;
endpackage

// File: rtl/xmem_page_bank.sv
module xmem_page_bank
    import xmem_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IO_SEL_W-1:0]   cfg_io_sel,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [IO_AW-1:0]      io_addr,
    input  logic [IO_DW-1:0]      io_wdata,
    output logic [IO_DW-1:0]      io_rdata,
    output logic                  io_rvalid,
    output page_reg_t [NUM_PAGES-1:0] page_regs
);
    logic [IO_AW-3:0]     io_base;
    logic                 lo_match;
    logic [NUM_PAGES-1:0] sel;
    page_reg_t            rd_mux;

    // Decode the slot-independent low part; both even and odd offsets match.
    assign io_base  = IO_BASE + (14'(cfg_io_sel) << IO_STEP_SH);
    assign lo_match = ({io_addr[IO_AW-3:1], 1'b0} == io_base);

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        assign sel[g] = lo_match &&
                        (io_addr[IO_AW-1 -: PAGE_IDX_W] == PAGE_IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                page_regs[g] <= '0;
            end else if (io_wr && sel[g]) begin
                page_regs[g] <= page_reg_t'(io_wdata);
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (sel[i]) begin
                rd_mux = rd_mux | page_regs[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_rvalid <= 1'b0;
            io_rdata  <= '0;
        end else begin
            io_rvalid <= io_rd && (|sel);
            io_rdata  <= (io_rd && (|sel)) ? IO_DW'(rd_mux) : '0;
        end
    end
endmodule

// File: rtl/xmem_window.sv
module xmem_window
    import xmem_pkg::*;
(
    input  logic                   cfg_ems_en,
    input  logic [FRAME_SEL_W-1:0] cfg_frame_sel,
    input  logic [EXT_REG_W-1:0]   cfg_ext,
    input  logic [SIZE_W-1:0]      cfg_size_code,
    input  page_reg_t [NUM_PAGES-1:0] page_regs,
    input  logic [CPU_AW-1:0]      cpu_addr,
    output logic                   hit,
    output logic [PHYS_AW-1:0]     phys
);
    logic [CPU_AW-1:0]     frame;
    logic [CPU_AW-1:0]     diff;
    logic                  in_win;
    logic [PAGE_IDX_W-1:0] idx;
    logic [PAGE_EXT_W-1:0] ext_arr [NUM_PAGES];
    logic [PNUM_W-1:0]     pnum;
    logic [COUNT_W-1:0]    count;
    logic [COUNT_W-1:0]    upper;
    logic                  in_range;

    // Slot 0 owns the top bits of the extension byte.
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_ext
        assign ext_arr[g] = cfg_ext[EXT_REG_W-1-PAGE_EXT_W*g -: PAGE_EXT_W];
    end

    assign frame    = FRAME_BASE + (CPU_AW'(cfg_frame_sel) << PAGE_OFF_W);
    assign diff     = cpu_addr - frame;
    assign in_win   = (cpu_addr >= frame) && (diff[CPU_AW-1:WIN_OFF_W] == '0);
    assign idx      = diff[WIN_OFF_W-1:PAGE_OFF_W];
    assign pnum     = {ext_arr[idx], page_regs[idx].num};
    assign count    = COUNT_W'(BASE_PAGES) << cfg_size_code;
    assign upper    = COUNT_W'(FIRST_PAGE) + count;
    assign in_range = ({1'b0, pnum} >= COUNT_W'(FIRST_PAGE)) && ({1'b0, pnum} < upper);
    assign hit      = cfg_ems_en && in_win && page_regs[idx].en && in_range;
    assign phys     = hit ? {pnum, cpu_addr[PAGE_OFF_W-1:0]} : PHYS_AW'(cpu_addr);
endmodule

// File: rtl/xmem_page_mapper.sv
module xmem_page_mapper
    import xmem_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_ems_en,
    input  logic [FRAME_SEL_W-1:0] cfg_frame_sel,
    input  logic [IO_SEL_W-1:0]    cfg_io_sel,
    input  logic [EXT_REG_W-1:0]   cfg_ext,
    input  logic [SIZE_W-1:0]      cfg_size_code,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic [IO_AW-1:0]       io_addr,
    input  logic [IO_DW-1:0]       io_wdata,
    output logic [IO_DW-1:0]       io_rdata,
    output logic                   io_rvalid,
    input  logic                   cpu_strobe,
    input  logic [CPU_AW-1:0]      cpu_addr,
    output logic                   xl_valid,
    output logic                   xl_hit,
    output logic [PHYS_AW-1:0]     xl_addr
);
    page_reg_t [NUM_PAGES-1:0] page_regs;
    logic                      win_hit;
    logic [PHYS_AW-1:0]        win_phys;
    xl_state_e                 state_q;
    xl_state_e                 state_d;

    xmem_page_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_io_sel (cfg_io_sel),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .io_rvalid  (io_rvalid),
        .page_regs  (page_regs)
    );

    xmem_window u_window (
        .cfg_ems_en    (cfg_ems_en),
        .cfg_frame_sel (cfg_frame_sel),
        .cfg_ext       (cfg_ext),
        .cfg_size_code (cfg_size_code),
        .page_regs     (page_regs),
        .cpu_addr      (cpu_addr),
        .hit           (win_hit),
        .phys          (win_phys)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = cpu_strobe ? ST_DRIVE : ST_IDLE;   // T_ACCEPT / T_WAIT
            ST_DRIVE: state_d = cpu_strobe ? ST_DRIVE : ST_IDLE;   // T_STREAM / T_RELEASE
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_hit  <= 1'b0;
            xl_addr <= '0;
        end else if (cpu_strobe) begin
            xl_hit  <= win_hit;
            xl_addr <= win_phys;
        end else begin
            xl_hit  <= 1'b0;
        end
    end

    assign xl_valid = (state_q == ST_DRIVE);
endmodule

// File: rtl/xmem_page_mapper_checker.sv
module xmem_page_mapper_checker
    import xmem_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_ems_en,
    input logic               io_rd,
    input logic               io_rvalid,
    input logic               cpu_strobe,
    input logic [CPU_AW-1:0]  cpu_addr,
    input logic               xl_valid,
    input logic               xl_hit,
    input logic [PHYS_AW-1:0] xl_addr
);
    assert_valid_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_strobe |=> xl_valid);

    assert_idle_without_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_strobe |=> !xl_valid);

    assert_hit_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_valid |-> !xl_hit);

    assert_global_off_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strobe && !cfg_ems_en) |=> (!xl_hit && xl_addr == PHYS_AW'($past(cpu_addr))));

    assert_hit_keeps_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_strobe |=> (!xl_hit ||
            xl_addr[PAGE_OFF_W-1:0] == $past(cpu_addr[PAGE_OFF_W-1:0])));

    assert_hit_page_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> (xl_addr[PHYS_AW-1:PAGE_OFF_W] >= PNUM_W'(FIRST_PAGE)));

    assert_rvalid_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> !io_rvalid);
endmodule

bind xmem_page_mapper xmem_page_mapper_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_ems_en (cfg_ems_en),
    .io_rd      (io_rd),
    .io_rvalid  (io_rvalid),
    .cpu_strobe (cpu_strobe),
    .cpu_addr   (cpu_addr),
    .xl_valid   (xl_valid),
    .xl_hit     (xl_hit),
    .xl_addr    (xl_addr)
);

// File: tb/xmem_page_mapper_tb.sv
`timescale 1ns/1ps
module xmem_page_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ems_en = 1'b0;
    logic [1:0]  cfg_frame_sel = '0;
    logic [2:0]  cfg_io_sel = '0;
    logic [7:0]  cfg_ext = '0;
    logic [1:0]  cfg_size_code = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic        cpu_strobe = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic        xl_valid;
    logic        xl_hit;
    logic [22:0] xl_addr;

    int errors = 0;
    int checks = 0;
    bit mdl_en [4];
    int mdl_num [4];

    always #4 clk = ~clk;

    xmem_page_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_ems_en(cfg_ems_en), .cfg_frame_sel(cfg_frame_sel),
        .cfg_io_sel(cfg_io_sel), .cfg_ext(cfg_ext), .cfg_size_code(cfg_size_code),
        .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_rvalid(io_rvalid), .cpu_strobe(cpu_strobe),
        .cpu_addr(cpu_addr), .xl_valid(xl_valid), .xl_hit(xl_hit), .xl_addr(xl_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] port_of(input int slot, input int k, input int odd);
        return 16'(slot * 'h4000 + 'h208 + k * 'h10 + odd);
    endfunction

    // Requirement model: returns {hit, 23-bit address}
    function automatic logic [23:0] model(input int a);
        int frame, idx, ext, p, cnt;
        bit hit;
        frame = 'hC0000 + int'(cfg_frame_sel) * 'h4000;
        hit = 1'b0;
        p = 0;
        if (a >= frame && a < frame + 'h10000) begin
            idx = (a - frame) / 'h4000;
            ext = (int'(cfg_ext) >> (6 - 2 * idx)) & 3;
            p = ext * 128 + mdl_num[idx];
            cnt = 32 << cfg_size_code;
            hit = cfg_ems_en && mdl_en[idx] && p >= 'h40 && p < 'h40 + cnt;
        end
        if (hit) return {1'b1, 23'(p * 'h4000 + a % 'h4000)};
        return {1'b0, 23'(a)};
    endfunction

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(posedge clk); @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic slot_write(input int slot, input int odd, input logic [7:0] d);
        io_write(port_of(slot, int'(cfg_io_sel), odd), d);
        mdl_en[slot] = d[7];
        mdl_num[slot] = int'(d[6:0]);
    endtask

    task automatic io_read_chk(input logic [15:0] a, input bit exp_v, input logic [7:0] exp_d, input string req);
        io_rd = 1'b1; io_addr = a;
        @(posedge clk); @(negedge clk);
        chk(io_rvalid == exp_v, req, 32'(io_rvalid), 32'(exp_v));
        if (exp_v) chk(io_rdata == exp_d, req, 32'(io_rdata), 32'(exp_d));
        io_rd = 1'b0;
    endtask

    task automatic strobe_chk(input int a, input string req);
        logic [23:0] e;
        e = model(a);
        cpu_strobe = 1'b1; cpu_addr = 20'(a);
        @(posedge clk); @(negedge clk);
        chk(xl_valid === 1'b1, req, 32'(xl_valid), 32'd1);
        chk({xl_hit, xl_addr} === e, req, 32'({xl_hit, xl_addr}), 32'(e));
        cpu_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ext_pat [5] = '{'h00, 'h55, 'hAA, 'hFF, 'hE4};
        for (int i = 0; i < 4; i++) begin mdl_en[i] = 1'b0; mdl_num[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(xl_valid == 1'b0 && xl_hit == 1'b0, "R1 outputs", 32'({xl_valid, xl_hit}), 32'd0);
        chk(io_rvalid == 1'b0, "R1 rvalid", 32'(io_rvalid), 32'd0);
        for (int i = 0; i < 4; i++) io_read_chk(port_of(i, 0, 0), 1'b1, 8'h00, "R1 page reset");

        // R9: valid follows strobe and drops after it
        cfg_ems_en = 1'b1;
        strobe_chk('hC0000, "R9 accept");
        strobe_chk('hC4000, "R9 stream");
        @(negedge clk);
        chk(xl_valid == 1'b0 && xl_hit == 1'b0, "R9 release", 32'({xl_valid, xl_hit}), 32'd0);

        // R2, R3, R4, R8, R10: every I/O base and window base
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 4; j++) begin
                int fr;
                cfg_io_sel = 3'(k); cfg_frame_sel = 2'(j);
                cfg_ext = 8'h00; cfg_size_code = 2'd0;
                fr = 'hC0000 + j * 'h4000;
                for (int i = 0; i < 4; i++) slot_write(i, i % 2, {1'b1, 7'('h40 + i * 5 + k)});
                for (int i = 0; i < 4; i++)
                    io_read_chk(port_of(i, k, (i + 1) % 2), 1'b1, {1'b1, 7'('h40 + i * 5 + k)}, "R3 readback");
                io_write(port_of(0, (k + 1) % 8, 0), 8'h00);
                io_read_chk(port_of(0, k, 0), 1'b1, {1'b1, 7'('h40 + k)}, "R2 alias ignored");
                io_read_chk(port_of(0, k, 2), 1'b0, 8'h00, "R3 unmatched read");
                for (int i = 0; i < 4; i++) strobe_chk(fr + i * 'h4000 + 'h123 + i, "R4 slot select");
                strobe_chk(fr - 1, "R8 below window");
                strobe_chk(fr + 'h10000, "R8 above window");
                slot_write(2, 0, 8'h80 | 8'('h41 + j));
                strobe_chk(fr + 2 * 'h4000 + 'h3FFF, "R10 immediate write");
            end
        end

        // R5, R6, R7: all page numbers, sizes and extension patterns
        cfg_io_sel = 3'd0; cfg_frame_sel = 2'd1;
        for (int s = 0; s < 4; s++) begin
            cfg_size_code = 2'(s);
            for (int e = 0; e < 5; e++) begin
                cfg_ext = 8'(ext_pat[e]);
                for (int v = 0; v < 128; v++) begin
                    slot_write(v % 4, 0, {1'b1, 7'(v)});
                    strobe_chk('hC4000 + (v % 4) * 'h4000 + v * 37, "R5 R6 R7 page sweep");
                end
            end
        end

        // R5: slot disable and global disable
        cfg_size_code = 2'd0; cfg_ext = 8'h00;
        slot_write(1, 0, 8'h50);
        strobe_chk('hC8000 + 'h10, "R5 slot disabled");
        slot_write(1, 0, 8'hD0);
        cfg_ems_en = 1'b0;
        strobe_chk('hC8000 + 'h10, "R5 global disabled");
        cfg_ems_en = 1'b1;
        strobe_chk('hC8000 + 'h10, "R5 re-enabled");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule